// File: doc/BRIEF.md
# Interleaved Stride DMA Address Generator

This block produces the quadword-by-quadword address stream for an interleaved transfer between a scratchpad and main memory. A start pulse hands it a total quadword count, a chunk size, a skip size, and base byte addresses for both sides. It then moves the transfer in chunks. Inside a chunk both addresses step by one quadword (16 bytes). At each chunk boundary the memory-side address also jumps over the skip region, while the scratchpad side stays contiguous.

Each quadword is offered through a request/ready handshake, and one quadword is accepted per cycle in which both are high. Two write-enable strobes say which side is written: memory, for scratchpad-to-memory moves, or scratchpad, for the opposite direction. The unit that moves the data sits outside the block and uses the presented addresses. A one-cycle done pulse marks the end of the transfer.

Top module: `ilv_addr_gen`

## Requirements
- R1: After reset, `req`, `busy`, `done`, `mem_we` and `spr_we` are low and `remaining` reads 0.
- R2: A `start` sampled while idle with `total_qw` non-zero raises `req` and `busy` on the next cycle. At that point `mem_addr` equals `mem_base`, `spr_addr` equals `spr_base` and `remaining` equals `total_qw`.
- R3: A quadword is accepted on each clock edge where `req` and `ready` are both high, and `remaining` then drops by one. While `ready` is low, `remaining` and both addresses hold.
- R4: `spr_addr` advances by 16 for each accepted quadword, with no gaps.
- R5: The chunk size is `xfer_qw` quadwords, and each chunk holds the smaller of that size and the remaining count. Within a chunk, `mem_addr` advances by 16 per accepted quadword.
- R6: After the last quadword of a chunk is accepted, `mem_addr` advances by 16 × (1 + `skip_qw`). For quadword i with chunk size t, the presented memory address is therefore `mem_base` + 16 × ((i / t) × (t + `skip_qw`) + i mod t).
- R7: An `xfer_qw` of 0 makes the whole count a single chunk, so no skip occurs during the transfer.
- R8: `dir` = 1 selects scratchpad-to-memory: `mem_we` is high and `spr_we` is low while `req` is high. `dir` = 0 selects the reverse. Both strobes are low whenever `req` is low.
- R9: `done` is high for exactly one cycle, in the cycle after the last quadword is accepted. At that point `req` is low and `remaining` reads 0. A start with `total_qw` = 0 gives that pulse on the next cycle and issues no request.
- R10: A `start` that arrives while `busy` is high is ignored, and the address sequence continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse, honoured only when idle |
| dir | input | 1 | 1 = scratchpad to memory, 0 = memory to scratchpad |
| total_qw | input | CNT_W | Total quadwords to move |
| xfer_qw | input | SZ_W | Chunk size in quadwords; 0 = whole count |
| skip_qw | input | SZ_W | Quadwords skipped on the memory side after each chunk |
| mem_base | input | MEM_AW | Memory start byte address |
| spr_base | input | SPR_AW | Scratchpad start byte address |
| req | output | 1 | A quadword is offered |
| ready | input | 1 | Accepts the offered quadword |
| mem_we | output | 1 | The offered quadword writes memory |
| spr_we | output | 1 | The offered quadword writes scratchpad |
| mem_addr | output | MEM_AW | Current memory byte address |
| spr_addr | output | SPR_AW | Current scratchpad byte address |
| remaining | output | CNT_W | Quadwords still to move |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
A start sampled on an edge makes the loaded state visible immediately after that edge, and each accepted quadword moves the addresses and the count on the very edge that accepts it. `done` appears one edge after the final acceptance and clears one edge later. The bench drives inputs and samples outputs on the falling edge. Each time it compares the presented addresses with quadword index i computed arithmetically, and it advances i only when it drove `ready` high for the edge just past. As a result, stalled cycles must show an unchanged index, and the done check falls on the first falling edge after the last accepting edge.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

    localparam int QW_BYTES = 16;

    typedef enum logic {
        DIR_TO_SPR = 1'b0,
        DIR_TO_MEM = 1'b1
    } ilv_dir_e;

    // Length of the next chunk: a zero size stands for "everything left".
    function automatic logic [31:0] chunk_len(input logic [31:0] size,
                                              input logic [31:0] left);
        if (size == 32'd0 || size > left)
            return left;
        return size;
    endfunction

endpackage

// File: rtl/ilv_chunk_ctl.sv
module ilv_chunk_ctl #(
    parameter int CNT_W = 16,
    parameter int SZ_W  = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] total,
    input  logic [SZ_W-1:0]  size,
    input  logic             accept,
    output logic             busy,
    output logic [CNT_W-1:0] remaining,
    output logic             chunk_end,
    output logic             done
);
    import ilv_pkg::*;

    logic [CNT_W-1:0] rem_q, left_q, rem_nx;
    logic [SZ_W-1:0]  size_q;
    logic             busy_q, done_q;

    assign rem_nx = rem_q - CNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q  <= '0;
            left_q <= '0;
            size_q <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (load) begin
                rem_q  <= total;
                size_q <= size;
                left_q <= CNT_W'(chunk_len(32'(size), 32'(total)));
                if (total == '0)
                    done_q <= 1'b1;
                else
                    busy_q <= 1'b1;
            end else if (busy_q && accept) begin
                rem_q <= rem_nx;
                if (rem_q == CNT_W'(1)) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
                if (left_q == CNT_W'(1))
                    left_q <= CNT_W'(chunk_len(32'(size_q), 32'(rem_nx)));
                else
                    left_q <= left_q - CNT_W'(1);
            end
        end
    end

    assign busy      = busy_q;
    assign remaining = rem_q;
    assign chunk_end = (left_q == CNT_W'(1));
    assign done      = done_q;

endmodule

// File: rtl/ilv_addr_ptr.sv
module ilv_addr_ptr #(
    parameter int AW      = 32,
    parameter int SZ_W    = 10,
    parameter bit STRIDED = 1'b1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic [AW-1:0]   base,
    input  logic [SZ_W-1:0] skip,
    input  logic            step,
    input  logic            chunk_end,
    output logic [AW-1:0]   addr
);
    import ilv_pkg::*;

    localparam logic [AW-1:0] QW_STEP = AW'(QW_BYTES);

    logic [AW-1:0] jump;
    logic [AW-1:0] addr_q;

    generate
        if (STRIDED) begin : g_stride
            logic [SZ_W-1:0] skip_q;
            always_ff @(posedge clk) begin
                if (rst)
                    skip_q <= '0;
                else if (load)
                    skip_q <= skip;
            end
            assign jump = AW'({skip_q, 4'b0000});
        end else begin : g_flat
            logic unused_skip;
            assign unused_skip = ^skip;
            assign jump = '0;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)
            addr_q <= '0;
        else if (load)
            addr_q <= base;
        else if (step)
            addr_q <= addr_q + QW_STEP + (chunk_end ? jump : '0);
    end

    assign addr = addr_q;

endmodule

// File: rtl/ilv_addr_gen.sv
module ilv_addr_gen #(
    parameter int CNT_W  = 16,
    parameter int SZ_W   = 10,
    parameter int MEM_AW = 32,
    parameter int SPR_AW = 14
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              dir,
    input  logic [CNT_W-1:0]  total_qw,
    input  logic [SZ_W-1:0]   xfer_qw,
    input  logic [SZ_W-1:0]   skip_qw,
    input  logic [MEM_AW-1:0] mem_base,
    input  logic [SPR_AW-1:0] spr_base,
    output logic              req,
    input  logic              ready,
    output logic              mem_we,
    output logic              spr_we,
    output logic [MEM_AW-1:0] mem_addr,
    output logic [SPR_AW-1:0] spr_addr,
    output logic [CNT_W-1:0]  remaining,
    output logic              busy,
    output logic              done
);
    import ilv_pkg::*;

    logic     load, accept, chunk_end, busy_i;
    ilv_dir_e dir_q;

    assign load   = start && !busy_i;
    assign accept = busy_i && ready;

    always_ff @(posedge clk) begin
        if (rst)
            dir_q <= DIR_TO_SPR;
        else if (load)
            dir_q <= ilv_dir_e'(dir);
    end

    ilv_chunk_ctl #(.CNT_W(CNT_W), .SZ_W(SZ_W)) u_ctl (
        .clk(clk), .rst(rst), .load(load), .total(total_qw), .size(xfer_qw),
        .accept(accept), .busy(busy_i), .remaining(remaining),
        .chunk_end(chunk_end), .done(done)
    );

    ilv_addr_ptr #(.AW(MEM_AW), .SZ_W(SZ_W), .STRIDED(1'b1)) u_mem_ptr (
        .clk(clk), .rst(rst), .load(load), .base(mem_base), .skip(skip_qw),
        .step(accept), .chunk_end(chunk_end), .addr(mem_addr)
    );

    ilv_addr_ptr #(.AW(SPR_AW), .SZ_W(SZ_W), .STRIDED(1'b0)) u_spr_ptr (
        .clk(clk), .rst(rst), .load(load), .base(spr_base), .skip(skip_qw),
        .step(accept), .chunk_end(chunk_end), .addr(spr_addr)
    );

    assign busy   = busy_i;
    assign req    = busy_i;
    assign mem_we = busy_i && (dir_q == DIR_TO_MEM);
    assign spr_we = busy_i && (dir_q == DIR_TO_SPR);

endmodule

// File: rtl/ilv_checker.sv
module ilv_checker #(
    parameter int CNT_W  = 16,
    parameter int MEM_AW = 32,
    parameter int SPR_AW = 14
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic [CNT_W-1:0]  total_qw,
    input logic [MEM_AW-1:0] mem_base,
    input logic              req,
    input logic              ready,
    input logic              mem_we,
    input logic              spr_we,
    input logic [MEM_AW-1:0] mem_addr,
    input logic [SPR_AW-1:0] spr_addr,
    input logic [CNT_W-1:0]  remaining,
    input logic              busy,
    input logic              done
);
    AST_LOAD_STATE: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && total_qw != '0) |=> (req && remaining == $past(total_qw) && mem_addr == $past(mem_base))); // R2
    AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (rst)
        (req && ready) |=> (remaining == $past(remaining) - CNT_W'(1))); // R3
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (req && !ready) |=> ($stable(mem_addr) && $stable(spr_addr) && $stable(remaining))); // R3
    AST_SPR_CONTIG: assert property (@(posedge clk) disable iff (rst)
        (req && ready) |=> (spr_addr == $past(spr_addr) + SPR_AW'(16))); // R4
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
        req |-> (mem_we != spr_we)); // R8
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !req |-> (!mem_we && !spr_we)); // R8
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R9
    AST_DONE_EMPTY: assert property (@(posedge clk) disable iff (rst)
        done |-> (remaining == '0 && !req)); // R9
endmodule

bind ilv_addr_gen ilv_checker #(.CNT_W(CNT_W), .MEM_AW(MEM_AW), .SPR_AW(SPR_AW)) u_chk (
    .clk(clk), .rst(rst), .start(start), .total_qw(total_qw), .mem_base(mem_base),
    .req(req), .ready(ready), .mem_we(mem_we), .spr_we(spr_we), .mem_addr(mem_addr),
    .spr_addr(spr_addr), .remaining(remaining), .busy(busy), .done(done)
);

// File: tb/ilv_addr_gen_test.sv
module ilv_addr_gen_test;
    localparam int CNT_W = 16, SZ_W = 10, MEM_AW = 32, SPR_AW = 14;

    logic clk = 1'b0, rst = 1'b1, start = 1'b0, dir = 1'b0, ready = 1'b0;
    logic [CNT_W-1:0]  total_qw = '0;
    logic [SZ_W-1:0]   xfer_qw = '0, skip_qw = '0;
    logic [MEM_AW-1:0] mem_base = '0;
    logic [SPR_AW-1:0] spr_base = '0;
    logic req, mem_we, spr_we, busy, done;
    logic [MEM_AW-1:0] mem_addr;
    logic [SPR_AW-1:0] spr_addr;
    logic [CNT_W-1:0]  remaining;

    int n_chk = 0, n_fail = 0, cyc = 0;

    always #4 clk = ~clk;

    ilv_addr_gen #(.CNT_W(CNT_W), .SZ_W(SZ_W), .MEM_AW(MEM_AW), .SPR_AW(SPR_AW)) uut (
        .clk(clk), .rst(rst), .start(start), .dir(dir), .total_qw(total_qw),
        .xfer_qw(xfer_qw), .skip_qw(skip_qw), .mem_base(mem_base), .spr_base(spr_base),
        .req(req), .ready(ready), .mem_we(mem_we), .spr_we(spr_we), .mem_addr(mem_addr),
        .spr_addr(spr_addr), .remaining(remaining), .busy(busy), .done(done)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic longint exp_mem(longint base, int i, int total, int xfer, int skip);
        int t = (xfer == 0) ? total : xfer;
        return base + 16 * ((i / t) * (t + skip) + i % t);
    endfunction

    task automatic run_case(input int total, input int xfer, input int skip, input bit d,
                            input longint mb, input int sb);
        int i = 0;
        @(negedge clk);
        total_qw = CNT_W'(total); xfer_qw = SZ_W'(xfer); skip_qw = SZ_W'(skip);
        mem_base = MEM_AW'(mb); spr_base = SPR_AW'(sb); dir = d; start = 1'b1; ready = 1'b0;
        @(negedge clk);
        start = 1'b0;
        if (total == 0) begin
            check(done == 1'b1, "R9 zero-count done", done, 1);
            check(req == 1'b0, "R9 zero-count no req", req, 0);
            @(negedge clk);
            check(done == 1'b0, "R9 done width", done, 0);
            return;
        end
        check(req && busy, "R2 req after start", req, 1);
        check(remaining == CNT_W'(total), "R2 remaining loaded", remaining, total);
        while (i < total) begin
            bit rdy;
            rdy = ((cyc % 3) != 2);
            cyc++;
            check(req == 1'b1, "R3 req held", req, 1);
            check(remaining == CNT_W'(total - i), "R3 remaining", remaining, total - i);
            check(spr_addr == SPR_AW'(sb + 16 * i), "R4 spr addr", spr_addr, SPR_AW'(sb + 16 * i));
            check(mem_addr == MEM_AW'(exp_mem(mb, i, total, xfer, skip)),
                  (xfer == 0) ? "R7 mem addr single chunk" : "R5 R6 mem addr stride",
                  mem_addr, MEM_AW'(exp_mem(mb, i, total, xfer, skip)));
            check(mem_we == d && spr_we == !d, "R8 write strobes", {mem_we, spr_we}, {d, !d});
            ready = rdy;
            if (i == 1) begin
                start = 1'b1; mem_base = ~mem_base; spr_base = ~spr_base; total_qw = 16'd3;
            end
            @(negedge clk);
            start = 1'b0; mem_base = MEM_AW'(mb); spr_base = SPR_AW'(sb); total_qw = CNT_W'(total);
            if (rdy) i++;
        end
        ready = 1'b0;
        check(done == 1'b1, "R9 done after last", done, 1);
        check(remaining == '0, "R9 remaining zero", remaining, 0);
        check(req == 1'b0 && !mem_we && !spr_we, "R8 R9 idle strobes", {req, mem_we, spr_we}, 0);
        if (total > 2) check(busy == 1'b0, "R10 restart ignored", busy, 0);
        @(negedge clk);
        check(done == 1'b0, "R9 done width", done, 0);
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!req && !busy && !done && !mem_we && !spr_we, "R1 reset outputs",
              {req, busy, done, mem_we, spr_we}, 0);
        check(remaining == '0, "R1 reset remaining", remaining, 0);
        for (int tot = 0; tot < 8; tot++)
            for (int x = 0; x < 4; x++)
                for (int s = 0; s < 3; s++)
                    run_case(tot, x, s, bit'((tot + x + s) % 2), 64'h1000 + 64'(256 * s), 16 * x);
        run_case(40, 10, 5, 1'b1, 64'hFFFF_FF00, 14'h3F00);
        run_case(25, 0, 7, 1'b0, 64'h2000, 16'h0100);
        run_case(9, 30, 2, 1'b1, 64'h4000, 16'h0040);
        run_case(12, 1, 1023, 1'b0, 64'h8000_0000, 16'h0000);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule